// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver

This block sits between a processor core and its interrupt sources. It takes one external interrupt pin, a set of peripheral request lines and one non-maskable external request. It applies each source's local enable and the core's two global mask bits, X and I. It then offers the core one request together with the low byte of the winning vector. The core answers with a one-cycle acknowledge when it takes the interrupt, and with a return pulse when the service routine ends.

The external interrupt pin has its own conditioner. In level mode the pin must stay low for two clock samples in a row. In edge mode a falling edge is latched until the core takes that vector. A promotion register lets software lift any one maskable source above the fixed default order. The register is written with that source's vector byte, and it accepts writes only while I is set. The block also holds the X and I mask bits. Software may clear X but can never set it, and each acceptance pushes the pre-interrupt X and I onto a small stack so the return pulse can restore them.

Top module: `irq_prio_resolver`

## Requirements
- R1: Source k (k = 0 is the external pin, k = 1..26 are `periph_req[k-1]`) has vector byte 0xF2 - 2k, and the non-maskable request uses 0xF4. With no promotion in effect the lowest eligible index wins, and `int_req` rises on the clock edge after a source becomes eligible.
- R2: A maskable source is eligible only while its `src_en` bit is 1 and `mask_i` is 0.
- R3: The promotion register keeps bits [7:1] of the written byte, and bit 0 has no effect. The maskable source whose vector matches outranks every other eligible maskable source. After reset the register selects the external pin (0xF2).
- R4: A promotion write made while `mask_i` is 0 leaves the register unchanged.
- R5: With `irq_edge_sel` = 0, the pin raises a request only after it is sampled low on two consecutive clock edges. A single low sample raises nothing.
- R6: With `irq_edge_sel` = 1, a falling edge is latched and stays pending while masked, until the core acknowledges vector 0xF2. A pin that is held low does not raise a new request.
- R7: `ack` while `int_req` is 1 is an acceptance. On the next edge `mask_i` becomes 1 and `int_req` falls.
- R8: `ccr_wr` loads `mask_i` from `ccr_i_wdata`. It can clear `mask_x` but never set it. Only reset, acceptance of the non-maskable request or a return can set X.
- R9: `xirq_n` low while `mask_x` is 0 wins over every maskable source with vector 0xF4, whatever the value of `mask_i`. Its acceptance sets both `mask_x` and `mask_i`.
- R10: `rti` restores X and I to the values they held just before the matching acceptance, nested up to 4 deep.
- R11: Once `int_req` is 1, `int_vec` holds its value until the acknowledge, even if a higher-ranked source arrives.
- R12: After reset `int_req` is 0, `mask_x` is 1 and `mask_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_n | input | 1 | External interrupt pin, active low |
| irq_edge_sel | input | 1 | 0: level mode, 1: falling-edge mode |
| xirq_n | input | 1 | Non-maskable external request, active low |
| periph_req | input | 26 | Peripheral request lines for sources 1..26 |
| src_en | input | 27 | Local enable per source, bit k for source k |
| prio_wr | input | 1 | Promotion register write strobe |
| prio_wdata | input | 8 | Vector byte of the source to promote |
| ccr_wr | input | 1 | Software write of the mask bits |
| ccr_x_wdata | input | 1 | New X value (clear only) |
| ccr_i_wdata | input | 1 | New I value |
| rti | input | 1 | Return from interrupt, restores the saved masks |
| ack | input | 1 | Core takes the offered interrupt |
| int_req | output | 1 | Interrupt request to the core |
| int_vec | output | 8 | Vector low byte of the offered interrupt |
| mask_x | output | 1 | Current X mask bit |
| mask_i | output | 1 | Current I mask bit |

## Verification
The bench attacks a single-sample low glitch on the pin in level mode. A conditioner with no filter would raise a spurious 0xF2 request. It also holds the pin low after an acknowledged edge in edge mode, where a latch that fails to clear, or a level fallback, would fire twice. A promotion write made with I clear is followed by competing requests: a missing lock would switch the winner from 0xDE to 0xEC. A write of 0xDF must promote the same source as 0xDE. Software first tries to set X again after clearing it, and then the non-maskable request and a maskable request arrive in the same cycle. A wrong design would either leave X set and block the request, or let the maskable source win. A late higher-ranked request during a pending grant must leave the vector unchanged.

// File: rtl/irqpr_pkg.sv
package irqpr_pkg;

   // vector low byte of maskable source idx, counting down in steps of two
   function automatic logic [7:0] src_vec(input logic [7:0] top, input int idx);
      return top - 8'(2 * idx);
   endfunction

endpackage

// File: rtl/irqpr_pin_cond.sv
module irqpr_pin_cond #(
   parameter int FILT_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr_pend,
   output logic req
);

   generate
      if (FILT_LEN < 2) begin : g_bad_filt
         $error("FILT_LEN must be at least 2");
      end
   endgenerate

   logic [FILT_LEN-1:0] hist_q;
   logic                pend_q;
   logic                level_ok;
   logic                fall;

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= '1;
      else        hist_q <= {hist_q[FILT_LEN-2:0], pin_n};
   end

   assign level_ok = ~|hist_q;
   assign fall     = hist_q[1] & ~hist_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= edge_mode & ((pend_q & ~clr_pend) | fall);
   end

   assign req = edge_mode ? pend_q : level_ok;

   // R6: a latched edge survives until the matching acknowledge
   p_pend_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && pend_q && !clr_pend) |=> pend_q);

   // R5: level request needs the two latest samples low
   p_level_filter_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && req) |-> (!$past(pin_n) && !$past(pin_n, 2)));

endmodule

// File: rtl/irqpr_mask_ctl.sv
module irqpr_mask_ctl #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic accept_nmi,
   input  logic rti,
   input  logic ccr_wr,
   input  logic wd_x,
   input  logic wd_i,
   output logic x_o,
   output logic i_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   localparam int IW = $clog2(DEPTH);
   localparam int PW = $clog2(DEPTH + 1);

   logic [1:0]    stk [DEPTH];
   logic [PW-1:0] ptr_q;
   logic [PW-1:0] top_p;
   logic          full;
   logic [IW-1:0] widx;
   logic          x_q, i_q;

   assign full  = (ptr_q == PW'(DEPTH));
   assign top_p = ptr_q - PW'(1);
   assign widx  = full ? IW'(DEPTH - 1) : ptr_q[IW-1:0];

   always_ff @(posedge clk) begin
      if (accept) stk[widx] <= {x_q, i_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q   <= 1'b1;
         i_q   <= 1'b1;
         ptr_q <= '0;
      end else if (accept) begin
         i_q <= 1'b1;
         if (accept_nmi) x_q <= 1'b1;
         if (!full) ptr_q <= ptr_q + PW'(1);
      end else if (rti && (ptr_q != '0)) begin
         {x_q, i_q} <= stk[top_p[IW-1:0]];
         ptr_q      <= top_p;
      end else if (ccr_wr) begin
         i_q <= wd_i;
         x_q <= x_q & wd_x;
      end
   end

   assign x_o = x_q;
   assign i_o = i_q;

   // R7: every acceptance leaves I set
   p_accept_sets_i_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> i_q);

   // R8: X only rises through a non-maskable acceptance or a return
   p_x_rise_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(x_q) |-> ($past(accept_nmi) || $past(rti)));

   // R9: non-maskable acceptance sets both masks
   p_nmi_sets_both_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      accept_nmi |=> (x_q && i_q));

endmodule

// File: rtl/irqpr_arbiter.sv
module irqpr_arbiter #(
   parameter int         NUM_SRC    = 27,
   parameter logic [7:0] VEC_TOP    = 8'hF2,
   parameter logic [7:0] NMI_VEC    = 8'hF4,
   parameter bit         PROMOTE_EN = 1'b1
) (
   input  logic [NUM_SRC-1:0] elig,
   input  logic               nmi,
   input  logic [6:0]         psel,
   output logic               any,
   output logic [7:0]         vec
);

   logic [NUM_SRC-1:0] hit;
   logic [NUM_SRC-1:0] pm;
   logic [7:0]         dvec;
   logic [7:0]         pvec;

   generate
      if (PROMOTE_EN) begin : g_prom
         for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
            localparam logic [7:0] SV = VEC_TOP - 8'(2 * g);
            assign hit[g] = (psel == SV[7:1]);
         end
      end else begin : g_noprom
         assign hit = '0;
      end
   endgenerate

   assign pm = elig & hit;

   always_comb begin
      dvec = '0;
      pvec = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i]) dvec = irqpr_pkg::src_vec(VEC_TOP, i);
         if (pm[i])   pvec = irqpr_pkg::src_vec(VEC_TOP, i);
      end
   end

   assign vec = nmi ? NMI_VEC : ((|pm) ? pvec : dvec);
   assign any = nmi | (|elig);

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
   parameter int         NUM_SRC     = 27,
   parameter logic [7:0] VEC_TOP     = 8'hF2,
   parameter logic [7:0] NMI_VEC     = 8'hF4,
   parameter int         FILT_LEN    = 2,
   parameter int         STACK_DEPTH = 4,
   parameter bit         PROMOTE_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_pin_n,
   input  logic               irq_edge_sel,
   input  logic               xirq_n,
   input  logic [NUM_SRC-2:0] periph_req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               prio_wr,
   input  logic [7:0]         prio_wdata,
   input  logic               ccr_wr,
   input  logic               ccr_x_wdata,
   input  logic               ccr_i_wdata,
   input  logic               rti,
   input  logic               ack,
   output logic               int_req,
   output logic [7:0]         int_vec,
   output logic               mask_x,
   output logic               mask_i
);

   localparam int LOW_VEC = int'(VEC_TOP) - 2 * (NUM_SRC - 1);

   generate
      if (NUM_SRC < 2 || LOW_VEC < 0) begin : g_bad_count
         $error("NUM_SRC does not fit below VEC_TOP");
      end
      if (int'(NMI_VEC) <= int'(VEC_TOP) && int'(NMI_VEC) >= LOW_VEC &&
          NMI_VEC[0] == VEC_TOP[0]) begin : g_bad_nmi
         $error("NMI_VEC collides with a maskable vector");
      end
   endgenerate

   logic               irq_line;
   logic               xirq_q;
   logic [6:0]         psel_q;
   logic               busy_q;
   logic [7:0]         vec_q;
   logic               mx, mi;
   logic [NUM_SRC-1:0] elig;
   logic               nmi_elig;
   logic               arb_any;
   logic [7:0]         arb_vec;
   logic               accept;
   logic               accept_nmi;
   logic               clr_pend;
   logic               wdata_unused;

   assign wdata_unused = prio_wdata[0];

   assign accept     = busy_q & ack;
   assign accept_nmi = accept & (vec_q == NMI_VEC);
   assign clr_pend   = accept & (vec_q == VEC_TOP);

   irqpr_pin_cond #(.FILT_LEN(FILT_LEN)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (irq_pin_n),
      .edge_mode (irq_edge_sel),
      .clr_pend  (clr_pend),
      .req       (irq_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) xirq_q <= 1'b1;
      else        xirq_q <= xirq_n;
   end

   irqpr_mask_ctl #(.DEPTH(STACK_DEPTH)) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .accept_nmi (accept_nmi),
      .rti        (rti),
      .ccr_wr     (ccr_wr),
      .wd_x       (ccr_x_wdata),
      .wd_i       (ccr_i_wdata),
      .x_o        (mx),
      .i_o        (mi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)              psel_q <= VEC_TOP[7:1];
      else if (prio_wr && mi)  psel_q <= prio_wdata[7:1];
   end

   assign elig     = {periph_req, irq_line} & src_en & {NUM_SRC{~mi}};
   assign nmi_elig = ~xirq_q & ~mx;

   irqpr_arbiter #(
      .NUM_SRC    (NUM_SRC),
      .VEC_TOP    (VEC_TOP),
      .NMI_VEC    (NMI_VEC),
      .PROMOTE_EN (PROMOTE_EN)
   ) u_arb (
      .elig (elig),
      .nmi  (nmi_elig),
      .psel (psel_q),
      .any  (arb_any),
      .vec  (arb_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         vec_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b0;
      end else if (!busy_q && arb_any) begin
         busy_q <= 1'b1;
         vec_q  <= arb_vec;
      end
   end

   assign int_req = busy_q;
   assign int_vec = vec_q;
   assign mask_x  = mx;
   assign mask_i  = mi;

   // R4: promotion register locked while I is clear
   p_prio_locked_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (prio_wr && !mi) |=> $stable(psel_q));

   // R11: offered vector frozen until acknowledge
   p_vec_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !ack) |=> (busy_q && $stable(vec_q)));

   // R2: a maskable grant only starts while I was clear
   p_masked_grant_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_q) && vec_q != NMI_VEC) |-> !$past(mi));

   // R9: the non-maskable grant only starts while X was clear
   p_nmi_gate_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_q) && vec_q == NMI_VEC) |-> !$past(mx));

endmodule

// File: tb/irq_prio_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_prio_resolver_tb_top;

   localparam int N = 27;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         irq_pin_n = 1'b1;
   logic         irq_edge_sel = 1'b0;
   logic         xirq_n = 1'b1;
   logic [N-2:0] periph_req = '0;
   logic [N-1:0] src_en = '0;
   logic         prio_wr = 1'b0;
   logic [7:0]   prio_wdata = '0;
   logic         ccr_wr = 1'b0;
   logic         ccr_x_wdata = 1'b1;
   logic         ccr_i_wdata = 1'b1;
   logic         rti = 1'b0;
   logic         ack = 1'b0;
   logic         int_req;
   logic [7:0]   int_vec;
   logic         mask_x;
   logic         mask_i;

   irq_prio_resolver dut_i (
      .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .irq_edge_sel(irq_edge_sel),
      .xirq_n(xirq_n), .periph_req(periph_req), .src_en(src_en), .prio_wr(prio_wr),
      .prio_wdata(prio_wdata), .ccr_wr(ccr_wr), .ccr_x_wdata(ccr_x_wdata),
      .ccr_i_wdata(ccr_i_wdata), .rti(rti), .ack(ack), .int_req(int_req),
      .int_vec(int_vec), .mask_x(mask_x), .mask_i(mask_i)
   );

   int    n_chk = 0;
   int    n_err = 0;
   string phase = "R12";
   bit    finished = 1'b0;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit         m_h0, m_h1, m_xq, m_pend, m_busy, m_x, m_i;
   logic [7:0] m_vec;
   logic [6:0] m_psel;
   bit [1:0]   m_stk[$];

   function automatic bit m_elig(int k, bit irq_on);
      bit r;
      if (k == 0) r = irq_on;
      else        r = periph_req[k-1];
      return r && src_en[k] && !m_i;
   endfunction

   always @(posedge clk) begin : model
      bit         irq_on, fall, nmi_ok, acc, old_i;
      int         win, pi;
      logic [7:0] pb;
      bit [1:0]   tmp;
      if (!rst_n) begin
         m_h0 = 1; m_h1 = 1; m_xq = 1; m_pend = 0; m_busy = 0;
         m_x = 1; m_i = 1; m_vec = 0; m_psel = 7'h79;
         m_stk.delete();
      end else begin
         irq_on = irq_edge_sel ? m_pend : (!m_h0 && !m_h1);
         fall   = m_h1 && !m_h0;
         nmi_ok = !m_xq && !m_x;
         win = -1;
         for (int k = 0; k < N; k++) if (win < 0 && m_elig(k, irq_on)) win = k;
         pb = {m_psel, 1'b0};
         pi = (242 - int'(pb)) / 2;
         if (win >= 0 && int'(pb) <= 242 && pi < N && m_elig(pi, irq_on)) win = pi;
         acc   = m_busy && ack;
         old_i = m_i;
         m_pend = irq_edge_sel && ((m_pend && !(acc && m_vec == 8'hF2)) || fall);
         m_h1 = m_h0; m_h0 = irq_pin_n; m_xq = xirq_n;
         if (prio_wr && old_i) m_psel = prio_wdata[7:1];
         if (acc) begin
            if (m_stk.size() < 4) m_stk.push_back({m_x, m_i});
            else m_stk[3] = {m_x, m_i};
            m_i = 1;
            if (m_vec == 8'hF4) m_x = 1;
         end else if (rti && m_stk.size() > 0) begin
            tmp = m_stk.pop_back();
            m_x = tmp[1]; m_i = tmp[0];
         end else if (ccr_wr) begin
            m_i = ccr_i_wdata;
            m_x = m_x && ccr_x_wdata;
         end
         if (acc) m_busy = 0;
         else if (!m_busy && (nmi_ok || win >= 0)) begin
            m_busy = 1;
            m_vec  = nmi_ok ? 8'hF4 : 8'(242 - 2 * win);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(phase, "model int_req", int'(int_req), int'(m_busy));
         chk(phase, "model int_vec", int'(int_vec), int'(m_vec));
         chk(phase, "model mask_x",  int'(mask_x),  int'(m_x));
         chk(phase, "model mask_i",  int'(mask_i),  int'(m_i));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_ccr(bit x, bit i);
      ccr_x_wdata = x; ccr_i_wdata = i; ccr_wr = 1'b1;
      step(1);
      ccr_wr = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1; step(1); ack = 1'b0;
   endtask

   task automatic pulse_rti();
      rti = 1'b1; step(1); rti = 1'b0;
   endtask

   task automatic pulse_prio(logic [7:0] v);
      prio_wdata = v; prio_wr = 1'b1; step(1); prio_wr = 1'b0;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin : watchdog
      #400000;
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin : main
      step(3);
      rst_n = 1'b1;
      step(1);
      // R12 reset state
      chk("R12", "int_req", int'(int_req), 0);
      chk("R12", "mask_x", int'(mask_x), 1);
      chk("R12", "mask_i", int'(mask_i), 1);

      // R1 default order, R2 local enable gating
      phase = "R1";
      periph_req[3] = 1'b1; periph_req[5] = 1'b1; periph_req[1] = 1'b1;
      src_en[4] = 1'b1; src_en[6] = 1'b1;
      pulse_ccr(1, 0);
      step(1);
      chk("R1", "int_req", int'(int_req), 1);
      chk("R2", "int_vec src4 over disabled src2", int'(int_vec), 'hEA);
      phase = "R7";
      pulse_ack();
      chk("R7", "mask_i after accept", int'(mask_i), 1);
      chk("R7", "int_req after accept", int'(int_req), 0);
      periph_req = '0;
      phase = "R10";
      pulse_rti();
      chk("R10", "mask_i restored", int'(mask_i), 0);

      // R3 promotion, bit 0 ignored
      phase = "R3";
      pulse_ccr(1, 1);
      pulse_prio(8'hDF);
      periph_req[9] = 1'b1; periph_req[1] = 1'b1;
      src_en[10] = 1'b1; src_en[2] = 1'b1;
      pulse_ccr(1, 0);
      step(1);
      chk("R3", "promoted vector", int'(int_vec), 'hDE);
      pulse_ack();
      periph_req = '0;
      pulse_rti();

      // R4 write with I clear ignored
      phase = "R4";
      pulse_prio(8'hEC);
      step(1);
      periph_req[2] = 1'b1; periph_req[9] = 1'b1; src_en[3] = 1'b1;
      step(1);
      chk("R4", "int_req", int'(int_req), 1);
      chk("R4", "promotion unchanged", int'(int_vec), 'hDE);
      pulse_ack();
      periph_req = '0;
      pulse_rti();

      // R11 vector hold against a later higher-ranked request
      phase = "R11";
      periph_req[19] = 1'b1; src_en[20] = 1'b1;
      step(1);
      chk("R11", "first vector", int'(int_vec), 'hCA);
      periph_req[1] = 1'b1; periph_req[9] = 1'b1;
      step(3);
      chk("R11", "int_req held", int'(int_req), 1);
      chk("R11", "vector held", int'(int_vec), 'hCA);
      pulse_ack();
      periph_req = '0;
      pulse_rti();

      // R5 level mode filter
      phase = "R5";
      src_en[0] = 1'b1; irq_edge_sel = 1'b0;
      irq_pin_n = 1'b0; step(1); irq_pin_n = 1'b1;
      step(4);
      chk("R5", "single low sample ignored", int'(int_req), 0);
      irq_pin_n = 1'b0;
      step(2);
      chk("R5", "one edge too early", int'(int_req), 0);
      step(1);
      chk("R5", "int_req after two lows", int'(int_req), 1);
      chk("R5", "int_vec pin", int'(int_vec), 'hF2);
      irq_pin_n = 1'b1;
      pulse_ack();
      pulse_rti();
      step(2);
      chk("R5", "pin high no request", int'(int_req), 0);

      // R6 edge mode latch
      phase = "R6";
      pulse_ccr(1, 1);
      irq_edge_sel = 1'b1;
      step(1);
      irq_pin_n = 1'b0;
      step(5);
      chk("R6", "masked edge waits", int'(int_req), 0);
      pulse_ccr(1, 0);
      step(1);
      chk("R6", "pending edge granted", int'(int_req), 1);
      chk("R6", "edge vector", int'(int_vec), 'hF2);
      pulse_ack();
      pulse_rti();
      step(4);
      chk("R6", "held-low pin no re-raise", int'(int_req), 0);
      irq_pin_n = 1'b1;
      src_en[0] = 1'b0;
      step(2);

      // R8 X clear-only, R9 non-maskable priority
      phase = "R8";
      chk("R8", "mask_x still set", int'(mask_x), 1);
      pulse_ccr(0, 1);
      chk("R8", "mask_x cleared", int'(mask_x), 0);
      pulse_ccr(1, 1);
      chk("R8", "software cannot set X", int'(mask_x), 0);
      periph_req[1] = 1'b1;
      step(1);
      phase = "R9";
      ccr_x_wdata = 1'b0; ccr_i_wdata = 1'b0; ccr_wr = 1'b1; xirq_n = 1'b0;
      step(1);
      ccr_wr = 1'b0;
      step(1);
      chk("R9", "non-maskable wins", int'(int_vec), 'hF4);
      pulse_ack();
      chk("R9", "mask_x set by accept", int'(mask_x), 1);
      chk("R9", "mask_i set by accept", int'(mask_i), 1);
      xirq_n = 1'b1; periph_req = '0;
      phase = "R10";
      pulse_rti();
      chk("R10", "mask_x restored", int'(mask_x), 0);
      chk("R10", "mask_i restored", int'(mask_i), 0);

      step(3);
      summary();
      $finish;
   end

endmodule